// File: doc/BRIEF.md
# Split Branch Prepare Queue

This block separates branch target calculation from branch resolution. A prepare request carries a base address, a signed offset and a 2-bit entry id. The block computes the target, stores it in that entry of a small table and asks the instruction fetch side to prefetch it. Up to three prepared targets may be held at once, so code can set up a target well before the branch that consumes it.

A branch request later names one entry and says whether the branch is taken. A taken branch on a prepared entry redirects fetch to the stored target and reports the short refill bubble of 4 cycles. A taken branch on an entry that holds nothing redirects to an address supplied with the branch and reports the full 8-cycle bubble. Every resolve frees the entry it names. A flush empties the whole table in one cycle. The fetch unit that consumes the prefetch and redirect outputs is outside this block.

Top module: `brprep_queue`

## Requirements
- R1: The stored target equals `prep_base` plus `prep_ofs` sign-extended to the address width, with wrap-around modulo 2^ADDR_W.
- R2: An accepted prepare writes entry `prep_id`. From the next cycle that entry is valid and a prefetch request for its target is pending.
- R3: `pf_valid` is high while any valid entry has a pending prefetch. `pf_id` and `pf_addr` show the lowest-numbered such entry. A request stays up until the cycle where `pf_ready` is high, and then it is dropped, so each prepare is prefetched once.
- R4: `prep_full` is high when three entries are valid. A prepare to an empty entry while `prep_full` is high is refused: the table is unchanged and `prep_reject` pulses for one cycle on the next cycle. A prepare to an entry that is already valid overwrites it even while full.
- R5: A taken branch on a valid entry raises `redir_valid` for one cycle on the next cycle, with `redir_addr` equal to the stored target and `redir_penalty` equal to 4.
- R6: A taken branch on an invalid entry raises `redir_valid` on the next cycle, with `redir_addr` equal to `br_alt_addr` and `redir_penalty` equal to 8.
- R7: A branch that is not taken produces no redirect. Any branch frees the entry it names and cancels that entry's pending prefetch.
- R8: `flush` invalidates every entry and every pending prefetch in one cycle. A prepare or branch presented in the same cycle is ignored: it causes no redirect and no reject.
- R9: A branch and a prepare in the same cycle both act on the table as it stood before that cycle. The branch reads the old entry, a prepare to the same id re-arms that entry, and the full decision uses only the entries valid before that cycle.
- R10: After reset no entry is valid and `prep_full`, `prep_reject`, `pf_valid` and `redir_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear the whole table |
| prep_valid | input | 1 | Prepare request |
| prep_id | input | IDW | Entry written by the prepare |
| prep_base | input | ADDR_W | Base address of the target |
| prep_ofs | input | OFS_W | Signed offset of the target |
| prep_full | output | 1 | Three entries are valid |
| prep_reject | output | 1 | Pulse: the prepare of the previous cycle was refused |
| pf_valid | output | 1 | Prefetch request |
| pf_ready | input | 1 | Fetch side accepts the prefetch request |
| pf_id | output | IDW | Entry whose target is being prefetched |
| pf_addr | output | ADDR_W | Prefetch address |
| br_valid | input | 1 | Branch resolve |
| br_id | input | IDW | Entry named by the branch |
| br_taken | input | 1 | Branch is taken |
| br_alt_addr | input | ADDR_W | Redirect address used when the entry is empty |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | ADDR_W | Redirect address |
| redir_penalty | output | PEN_W | Bubble length of the redirect, in cycles |

## Verification
The bench goes after the fourth prepare while three entries are live. A design that counted only accepted writes would let a fourth entry in, and one that refused overwrites would drop a legal re-target. It holds `pf_ready` low for several cycles and then frees the pending entry. A broken hold would lose or repeat a prefetch, and a broken cancel would prefetch a dead target. It places a branch and a prepare to the same id in one cycle, and places flush on top of both. A wrong priority there shows up as a redirect to the new target, a lost re-arm, or a redirect that survives a flush. Negative offsets and the empty-entry fallback expose a zero-extended offset and a penalty or address taken from the wrong source.

// File: rtl/brprep_pkg.sv
package brprep_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_FAST = 2'd1,
    RK_SLOW = 2'd2
  } redir_kind_e;

  function automatic int unsigned penalty_of(input redir_kind_e kind,
                                             input int unsigned fast_pen,
                                             input int unsigned slow_pen);
    case (kind)
      RK_FAST: return fast_pen;
      RK_SLOW: return slow_pen;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/brprep_table.sv
module brprep_table #(
  parameter int unsigned IDW      = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned MAX_PEND = 3,
  localparam int unsigned ENTRIES = 1 << IDW,
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           wr_en,
  input  logic [IDW-1:0]                 wr_id,
  input  logic [ADDR_W-1:0]              wr_base,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic                           free_en,
  input  logic [IDW-1:0]                 free_id,
  input  logic                           clr_en,
  input  logic [IDW-1:0]                 clr_id,
  output logic [ENTRIES-1:0]             ent_valid,
  output logic [ENTRIES-1:0]             ent_pend,
  output logic [ENTRIES-1:0][ADDR_W-1:0] ent_tgt,
  output logic [CNT_W-1:0]               occ_cnt
);

  // Target arithmetic: base plus sign-extended offset, wrapping.
  function automatic logic [ADDR_W-1:0] calc_target(input logic [ADDR_W-1:0] b,
                                                    input logic [OFS_W-1:0]  o);
    logic [ADDR_W-1:0] sx;
    sx = {{(ADDR_W-OFS_W){o[OFS_W-1]}}, o};
    return b + sx;
  endfunction

  function automatic logic [CNT_W-1:0] count_ones(input logic [ENTRIES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [ADDR_W-1:0] new_tgt;
  assign new_tgt = calc_target(wr_base, wr_ofs);
  assign occ_cnt = count_ones(ent_valid);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [IDW-1:0] MY_ID = IDW'(g);
    logic hit_wr, hit_free, hit_clr;
    assign hit_wr   = wr_en   && (wr_id   == MY_ID);
    assign hit_free = free_en && (free_id == MY_ID);
    assign hit_clr  = clr_en  && (clr_id  == MY_ID);

    // Priority: flush > write > free > prefetch-done.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_pend[g]  <= 1'b0;
        ent_tgt[g]   <= '0;
      end else if (flush) begin
        ent_valid[g] <= 1'b0;
        ent_pend[g]  <= 1'b0;
      end else if (hit_wr) begin
        ent_valid[g] <= 1'b1;
        ent_pend[g]  <= 1'b1;
        ent_tgt[g]   <= new_tgt;
      end else if (hit_free) begin
        ent_valid[g] <= 1'b0;
        ent_pend[g]  <= 1'b0;
      end else if (hit_clr) begin
        ent_pend[g]  <= 1'b0;
      end
    end

    AST_PEND_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ent_pend[g] |-> ent_valid[g]); // R3
  end

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= CNT_W'(MAX_PEND)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0) && (ent_pend == '0)); // R8

endmodule

// File: rtl/brprep_pf_arb.sv
module brprep_pf_arb #(
  parameter int unsigned IDW    = 2,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned ENTRIES = 1 << IDW
) (
  input  logic [ENTRIES-1:0]             ent_pend,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tgt,
  output logic                           pf_valid,
  output logic [IDW-1:0]                 pf_id,
  output logic [ADDR_W-1:0]              pf_addr
);

  // Lowest-numbered pending entry wins.
  always_comb begin
    pf_valid = 1'b0;
    pf_id    = '0;
    pf_addr  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_pend[i]) begin
        pf_valid = 1'b1;
        pf_id    = IDW'(i);
        pf_addr  = ent_tgt[i];
      end
    end
  end

endmodule

// File: rtl/brprep_redirect.sv
module brprep_redirect
  import brprep_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned FAST_PEN = 4,
  parameter int unsigned SLOW_PEN = 8,
  localparam int unsigned PEN_W   = $clog2(SLOW_PEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_fire,
  input  logic              br_taken,
  input  logic              hit_valid,
  input  logic [ADDR_W-1:0] hit_tgt,
  input  logic [ADDR_W-1:0] alt_addr,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic [PEN_W-1:0]  redir_penalty
);

  redir_kind_e kind;

  always_comb begin
    if (!br_fire || !br_taken) kind = RK_NONE;
    else if (hit_valid)        kind = RK_FAST;
    else                       kind = RK_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid   <= 1'b0;
      redir_addr    <= '0;
      redir_penalty <= '0;
    end else begin
      redir_valid   <= (kind != RK_NONE);
      redir_addr    <= (kind == RK_FAST) ? hit_tgt : alt_addr;
      redir_penalty <= PEN_W'(penalty_of(kind, FAST_PEN, SLOW_PEN));
    end
  end

  AST_PEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_penalty == PEN_W'(FAST_PEN)) ||
                    (redir_penalty == PEN_W'(SLOW_PEN))); // R5

  AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fire && !br_taken) |=> !redir_valid); // R7

endmodule

// File: rtl/brprep_queue.sv
module brprep_queue #(
  parameter int unsigned IDW      = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned MAX_PEND = 3,
  parameter int unsigned FAST_PEN = 4,
  parameter int unsigned SLOW_PEN = 8,
  localparam int unsigned ENTRIES = 1 << IDW,
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1),
  localparam int unsigned PEN_W   = $clog2(SLOW_PEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              prep_valid,
  input  logic [IDW-1:0]    prep_id,
  input  logic [ADDR_W-1:0] prep_base,
  input  logic [OFS_W-1:0]  prep_ofs,
  output logic              prep_full,
  output logic              prep_reject,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [IDW-1:0]    pf_id,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              br_valid,
  input  logic [IDW-1:0]    br_id,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_alt_addr,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic [PEN_W-1:0]  redir_penalty
);

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0]             ent_pend;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tgt;
  logic [CNT_W-1:0]               occ_cnt;

  // Named internal events.
  logic prep_fire, prep_live_id, prep_accept, prep_refuse;
  logic br_fire, pf_fire;

  assign prep_full    = (occ_cnt >= CNT_W'(MAX_PEND));
  assign prep_fire    = prep_valid && !flush;
  assign prep_live_id = ent_valid[prep_id];
  assign prep_accept  = prep_fire && (prep_live_id || !prep_full);
  assign prep_refuse  = prep_fire && !prep_live_id && prep_full;
  assign br_fire      = br_valid && !flush;
  assign pf_fire      = pf_valid && pf_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prep_reject <= 1'b0;
    else        prep_reject <= prep_refuse;
  end

  brprep_table #(
    .IDW(IDW), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .MAX_PEND(MAX_PEND)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(prep_accept), .wr_id(prep_id), .wr_base(prep_base), .wr_ofs(prep_ofs),
    .free_en(br_fire), .free_id(br_id),
    .clr_en(pf_fire), .clr_id(pf_id),
    .ent_valid(ent_valid), .ent_pend(ent_pend), .ent_tgt(ent_tgt),
    .occ_cnt(occ_cnt)
  );

  brprep_pf_arb #(.IDW(IDW), .ADDR_W(ADDR_W)) u_arb (
    .ent_pend(ent_pend), .ent_tgt(ent_tgt),
    .pf_valid(pf_valid), .pf_id(pf_id), .pf_addr(pf_addr)
  );

  brprep_redirect #(
    .ADDR_W(ADDR_W), .FAST_PEN(FAST_PEN), .SLOW_PEN(SLOW_PEN)
  ) u_redir (
    .clk(clk), .rst_n(rst_n),
    .br_fire(br_fire), .br_taken(br_taken),
    .hit_valid(ent_valid[br_id]), .hit_tgt(ent_tgt[br_id]),
    .alt_addr(br_alt_addr),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .redir_penalty(redir_penalty)
  );

  AST_REJECT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    prep_reject |-> $past(prep_full)); // R4

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !flush && !br_valid && !prep_valid)
      |=> pf_valid && $stable(pf_addr) && $stable(pf_id)); // R3

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pf_valid && !prep_full && !redir_valid && !prep_reject); // R8

endmodule

// File: tb/brprep_queue_tb.sv
module brprep_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush, prep_valid, pf_ready, br_valid, br_taken;
  logic [1:0]  prep_id, br_id;
  logic [31:0] prep_base, br_alt_addr;
  logic [15:0] prep_ofs;
  logic        prep_full, prep_reject, pf_valid, redir_valid;
  logic [1:0]  pf_id;
  logic [31:0] pf_addr, redir_addr;
  logic [3:0]  redir_penalty;

  always #(CLK_PERIOD/2) clk = ~clk;

  brprep_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .prep_valid(prep_valid), .prep_id(prep_id), .prep_base(prep_base), .prep_ofs(prep_ofs),
    .prep_full(prep_full), .prep_reject(prep_reject),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_id(pf_id), .pf_addr(pf_addr),
    .br_valid(br_valid), .br_id(br_id), .br_taken(br_taken), .br_alt_addr(br_alt_addr),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .redir_penalty(redir_penalty)
  );

  // Behavioural reference state
  bit          m_v[ENT];
  bit          m_p[ENT];
  bit [31:0]   m_t[ENT];
  bit          e_rv, e_rej;
  bit [31:0]   e_ra;
  int          e_rp;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  task automatic expect_eq(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int live_count();
    int c = 0;
    foreach (m_v[i]) if (m_v[i]) c++;
    return c;
  endfunction

  function automatic int first_pend();
    foreach (m_p[i]) if (m_p[i]) return i;
    return -1;
  endfunction

  task automatic compare();
    int fp = first_pend();
    expect_eq("R4", "prep_full", prep_full, live_count() >= 3);
    expect_eq("R4", "prep_reject", prep_reject, e_rej);
    expect_eq("R3", "pf_valid", pf_valid, fp >= 0);
    if (fp >= 0) begin
      expect_eq("R3", "pf_id", pf_id, fp);
      expect_eq("R1", "pf_addr", pf_addr, m_t[fp]);
    end
    expect_eq("R7", "redir_valid", redir_valid, e_rv);
    if (e_rv) begin
      expect_eq(e_rp == 4 ? "R5" : "R6", "redir_addr", redir_addr, e_ra);
      expect_eq(e_rp == 4 ? "R5" : "R6", "redir_penalty", redir_penalty, e_rp);
    end
  endtask

  task automatic model_update();
    int  fp = first_pend();
    bit  full0 = live_count() >= 3;
    e_rv = 0; e_rej = 0;
    if (flush) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_p[i] = 0; end
      return;
    end
    if (br_valid && br_taken) begin
      e_rv = 1;
      if (m_v[br_id]) begin e_ra = m_t[br_id]; e_rp = 4; end
      else begin e_ra = br_alt_addr; e_rp = 8; end
    end
    begin
      bit acc = prep_valid && (m_v[prep_id] || !full0);
      e_rej = prep_valid && !m_v[prep_id] && full0;
      if (fp >= 0 && pf_ready) m_p[fp] = 0;
      if (br_valid) begin m_v[br_id] = 0; m_p[br_id] = 0; end
      if (acc) begin
        m_v[prep_id] = 1; m_p[prep_id] = 1;
        m_t[prep_id] = prep_base + 32'($signed(prep_ofs));
      end
    end
  endtask

  task automatic idle();
    flush = 0; prep_valid = 0; prep_id = 0; prep_base = 0; prep_ofs = 0;
    br_valid = 0; br_id = 0; br_taken = 0; br_alt_addr = 0; pf_ready = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic prep(input logic [1:0] id, input logic [31:0] b, input logic [15:0] o);
    prep_valid = 1; prep_id = id; prep_base = b; prep_ofs = o;
  endtask

  task automatic branch(input logic [1:0] id, input logic tk, input logic [31:0] alt);
    br_valid = 1; br_id = id; br_taken = tk; br_alt_addr = alt;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    expect_eq("R10", "prep_full", prep_full, 0);
    expect_eq("R10", "prep_reject", prep_reject, 0);
    expect_eq("R10", "pf_valid", pf_valid, 0);
    expect_eq("R10", "redir_valid", redir_valid, 0);

    // R1 R2: negative offset, prefetch held with ready low
    prep(2'd2, 32'h0000_1000, 16'hFFF0); pf_ready = 0; tick();
    expect_eq("R2", "pf_addr", pf_addr, 32'h0000_0FF0);
    expect_eq("R2", "pf_id", pf_id, 2);
    pf_ready = 0; tick();
    pf_ready = 0; tick();
    expect_eq("R3", "pf held", pf_valid, 1);
    tick();
    expect_eq("R3", "pf once", pf_valid, 0);
    // wrap-around
    prep(2'd0, 32'hFFFF_FFF0, 16'h0020); tick();
    expect_eq("R1", "wrap", pf_addr, 32'h0000_0010);
    // fill third entry, then fourth refused, then overwrite allowed
    prep(2'd1, 32'h0000_2000, 16'h0004); tick();
    expect_eq("R4", "full", prep_full, 1);
    prep(2'd3, 32'h0000_3000, 16'h0000); tick();
    expect_eq("R4", "reject", prep_reject, 1);
    prep(2'd1, 32'h0000_5000, 16'h0008); tick();
    expect_eq("R4", "no reject on overwrite", prep_reject, 0);
    // R5 taken valid, R6 taken invalid, R7 not taken
    branch(2'd1, 1, 32'hDEAD_0000); tick();
    expect_eq("R5", "fast addr", redir_addr, 32'h0000_5008);
    expect_eq("R5", "fast pen", redir_penalty, 4);
    branch(2'd3, 1, 32'hBEEF_0000); tick();
    expect_eq("R6", "slow addr", redir_addr, 32'hBEEF_0000);
    expect_eq("R6", "slow pen", redir_penalty, 8);
    branch(2'd0, 0, 32'h0); tick();
    expect_eq("R7", "no redirect", redir_valid, 0);
    branch(2'd0, 1, 32'h0000_0777); tick();
    expect_eq("R7", "freed", redir_penalty, 8);
    // R7 free cancels pending prefetch
    prep(2'd3, 32'h0000_4000, 16'h0); pf_ready = 0; tick();
    branch(2'd3, 0, 32'h0); pf_ready = 0; tick();
    expect_eq("R7", "pf cancel", pf_valid, 0);
    // R9 same-cycle branch and prepare on one id
    prep(2'd2, 32'h0000_6000, 16'h0); tick();
    branch(2'd2, 1, 32'h0); prep(2'd2, 32'h0000_7000, 16'h0); tick();
    expect_eq("R9", "old target", redir_addr, 32'h0000_6000);
    expect_eq("R9", "rearm", pf_addr, 32'h0000_7000);
    // R8 flush beats same-cycle prepare and branch
    prep(2'd0, 32'h100, 16'h0); tick();
    prep(2'd1, 32'h200, 16'h0); tick();
    flush = 1; branch(2'd2, 1, 32'h0); prep(2'd3, 32'h300, 16'h0); tick();
    expect_eq("R8", "redirect", redir_valid, 0);
    expect_eq("R8", "pf", pf_valid, 0);
    expect_eq("R8", "full", prep_full, 0);

    // Random traffic compared every cycle
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(99) < 45)
        prep(2'($urandom), $urandom, 16'($urandom));
      if ($urandom_range(99) < 30)
        branch(2'($urandom), 1'($urandom), $urandom);
      flush    = ($urandom_range(99) < 3);
      pf_ready = ($urandom_range(99) < 55);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule